// File: doc/BRIEF.md
# Dual-Mode Display Memory DRAM Controller

This block sits between a single requester (a display refresh engine or a host port, arbitrated upstream) and one 16-bit DRAM device with a 10-bit multiplexed address bus. Each request carries a 20-bit word address, two byte enables, write data and a direction. The controller runs one full RAS cycle per access: the row goes out first, then the column. It returns a one-clock done strobe, with read data on reads.

Three active-low strobe pins drive the byte lanes. Their meaning is set by a strap input. In the split-CAS arrangement the pins are upper CAS, lower CAS and one shared write enable. In the split-WE arrangement the pins are a single CAS, lower write enable and upper write enable. A second strap selects the page timing. Normal timing holds CAS low for two clocks and samples read data before CAS rises. Extended-data-out timing holds CAS low for one clock and samples read data one clock after CAS rises.

A free-running timer asks for a CAS-before-RAS refresh every 256 clocks. A pending refresh takes precedence over a new request. A request that finds the controller busy keeps its valid high until it is accepted.

Top module: `vmc_dram_ctrl`

## Requirements
- R1: While RAS is driven low for an access, `dram_addr` carries `req_addr[19:10]` (the row). While CAS is low, `dram_addr` carries `req_addr[9:0]` (the column).
- R2: With `cfg_two_we`=0, pin A is upper CAS, pin B is lower CAS and pin C is a shared write enable, all active low. A write pulls the CAS of each lane whose enable is set (`req_be[1]` upper, `req_be[0]` lower) and pulls pin C. A read pulls both CAS pins and leaves pin C high.
- R3: With `cfg_two_we`=1, pin A is the only CAS and falls on every access. Pin B is the lower write enable, pulled for a write with `req_be[0]`. Pin C is the upper write enable, pulled for a write with `req_be[1]`.
- R4: With `cfg_edo`=0, CAS stays low for two clocks. Read data is taken from `dram_dq_i` at the clock edge that ends the second CAS-low clock.
- R5: With `cfg_edo`=1, CAS stays low for one clock. Read data is taken at the edge that ends the following clock, in which CAS is high and RAS is still low.
- R6: `rsp_done` is a one-clock pulse. It appears in the 4th clock after the accepting edge for normal-timing accesses and for EDO reads, and in the 3rd clock for EDO writes. `rsp_rdata` is valid while done is high.
- R7: Refresh happens once per 256 clocks, with a tolerance of one over a run. All CAS pins go low one clock before RAS falls. No write enable is active at any point of the refresh.
- R8: While a refresh is pending or running, `req_ready` is low. A request held valid through that time is served afterwards and is not lost.
- R9: Between two RAS-low periods, RAS stays high for at least 2 clocks. CAS of an access falls at least 1 clock after RAS fell.
- R10: A write with both byte enables clear is accepted, and `rsp_done` pulses in the next clock. During it RAS, every CAS and every write enable stay high.
- R11: During and right after reset, RAS and all strobe pins are high, `dram_dq_oe` and `rsp_done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_two_we | input | 1 | Strobe arrangement: 0 split CAS, 1 split WE (static) |
| cfg_edo | input | 1 | Page timing: 0 normal, 1 EDO (static) |
| req_valid | input | 1 | Request present, held until accepted |
| req_ready | output | 1 | Request accepted at an edge where valid and ready are both high |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 20 | Word address, row in bits 19:10, column in bits 9:0 |
| req_be | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-clock completion strobe |
| rsp_rdata | output | 16 | Read data, valid with done |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_stb_a_n | output | 1 | Strobe pin A (upper CAS or single CAS) |
| dram_stb_b_n | output | 1 | Strobe pin B (lower CAS or lower WE) |
| dram_stb_c_n | output | 1 | Strobe pin C (shared WE or upper WE) |
| dram_dq_o | output | 16 | Write data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 16 | Read data from the DRAM |

## Verification
The bench pairs a pin-level DRAM model with a reference memory. Reads are tried in all four combinations of strobe arrangement and page timing. The model drives valid data only inside the window its timing allows and a poison word outside it, so a read sampled at the wrong edge returns the poison word. Full-word, upper-only, lower-only and empty writes, each followed by a read, separate lane mapping errors from row/column swaps. Corner addresses and random traffic follow. Requests are also parked on the start of a refresh, which tests precedence and that no request is lost.

// File: rtl/vmc_pkg.sv
package vmc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACT,
    ST_CAS1,
    ST_CAS2,
    ST_HOLD,
    ST_PRE,
    ST_REF_CAS,
    ST_REF_RAS1,
    ST_REF_RAS2
  } vmc_state_e;

  // per-lane CAS request (active high): reads open both lanes
  function automatic logic [1:0] lane_cas(input logic is_wr, input logic [1:0] be);
    return is_wr ? be : 2'b11;
  endfunction

  // per-lane write enable request (active high)
  function automatic logic [1:0] lane_we(input logic is_wr, input logic [1:0] be);
    return is_wr ? be : 2'b00;
  endfunction

  // fold active-high lane strobes onto the three active-low pins {a,b,c}
  function automatic logic [2:0] pin_fold(input logic two_we,
                                          input logic [1:0] cas,
                                          input logic [1:0] we);
    logic [2:0] p;
    if (two_we) p = {~(|cas), ~we[0], ~we[1]};
    else        p = {~cas[1], ~cas[0], ~(|we)};
    return p;
  endfunction

  // clocks from accepting edge to the clock in which done is seen
  function automatic int unsigned done_latency(input logic edo,
                                               input logic is_wr,
                                               input logic [1:0] be);
    if (is_wr && be == 2'b00) return 1;
    if (edo && is_wr)         return 3;
    return 4;
  endfunction

endpackage

// File: rtl/vmc_refresh_timer.sv
module vmc_refresh_timer #(
  parameter int unsigned PERIOD = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_taken,
  output logic ref_pending
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      ref_pending <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)           ref_pending <= 1'b1;
      else if (ref_taken) ref_pending <= 1'b0;
    end
  end

  // R7: a request for refresh is never lost before it is taken
  a_r7_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pending && !ref_taken) |=> ref_pending);

endmodule

// File: rtl/vmc_sequencer.sv
module vmc_sequencer
  import vmc_pkg::*;
#(
  parameter int unsigned AW      = 10,
  parameter int unsigned DW      = 16,
  parameter int unsigned RP_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_edo,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2*AW-1:0]   req_addr,
  input  logic [DW/8-1:0]   req_be,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DW-1:0]     rsp_rdata,
  input  logic              ref_pending,
  output logic              ref_taken,
  output logic              ras_on,
  output logic              cas_on,
  output logic              ref_cas,
  output logic              wr_q,
  output logic [DW/8-1:0]   be_q,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     wdata_q,
  output logic              dq_oe,
  input  logic [DW-1:0]     dq_i,
  output logic              ev_col_first,
  output logic              ev_ref_ras_first,
  output logic              ev_null,
  output logic              ev_ref_any
);
  localparam int unsigned PCW = $clog2(RP_CLKS + 1);

  vmc_state_e     state_q, state_d;
  logic [PCW-1:0] pre_q;
  logic [AW-1:0]  row_q, col_q;
  logic           accept, null_wr, finish;

  assign req_ready = (state_q == ST_IDLE) && !ref_pending;
  assign accept    = req_valid && req_ready;
  assign null_wr   = accept && req_write && (req_be == '0);
  assign ref_taken = (state_q == ST_IDLE) && ref_pending;

  // last clock of an access's column phase
  assign finish = (state_q == ST_CAS2) || (state_q == ST_HOLD) ||
                  ((state_q == ST_CAS1) && cfg_edo && wr_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pending)          state_d = ST_REF_CAS;
        else if (accept && !null_wr) state_d = ST_ACT;
      end
      ST_ACT:      state_d = ST_CAS1;
      ST_CAS1: begin
        if (!cfg_edo)  state_d = ST_CAS2;
        else if (wr_q) state_d = ST_PRE;
        else           state_d = ST_HOLD;
      end
      ST_CAS2:     state_d = ST_PRE;
      ST_HOLD:     state_d = ST_PRE;
      ST_PRE:      state_d = (pre_q == PCW'(RP_CLKS - 1)) ? ST_IDLE : ST_PRE;
      ST_REF_CAS:  state_d = ST_REF_RAS1;
      ST_REF_RAS1: state_d = ST_REF_RAS2;
      ST_REF_RAS2: state_d = ST_PRE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pre_q     <= '0;
      row_q     <= '0;
      col_q     <= '0;
      wr_q      <= 1'b0;
      be_q      <= '0;
      wdata_q   <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state_q  <= state_d;
      pre_q    <= (state_q == ST_PRE) ? pre_q + 1'b1 : '0;
      rsp_done <= finish || null_wr;
      if (accept) begin
        row_q   <= req_addr[2*AW-1:AW];
        col_q   <= req_addr[AW-1:0];
        wr_q    <= req_write;
        be_q    <= req_be;
        wdata_q <= req_wdata;
      end
      if (finish && !wr_q) rsp_rdata <= dq_i;
    end
  end

  assign ras_on   = (state_q == ST_ACT) || (state_q == ST_CAS1) || (state_q == ST_CAS2) ||
                    (state_q == ST_HOLD) || (state_q == ST_REF_RAS1) || (state_q == ST_REF_RAS2);
  assign cas_on   = (state_q == ST_CAS1) || (state_q == ST_CAS2);
  assign ref_cas  = (state_q == ST_REF_CAS) || (state_q == ST_REF_RAS1) || (state_q == ST_REF_RAS2);
  assign dq_oe    = cas_on && wr_q;
  assign mem_addr = (state_q == ST_ACT) ? row_q :
                    (cas_on || state_q == ST_HOLD) ? col_q : '0;

  // named events for the checks at the top level
  assign ev_col_first     = (state_q == ST_CAS1);
  assign ev_ref_ras_first = (state_q == ST_REF_RAS1);
  assign ev_null          = null_wr;
  assign ev_ref_any       = ref_cas;

  // R8: refresh is started ahead of a waiting request
  a_r8_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && ref_pending && req_valid) |=> (state_q == ST_REF_CAS));

  // R6: done follows the end of a column phase by one edge
  a_r6_done_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && state_q != ST_IDLE) |=> rsp_done);

  // R9: precharge lasts RP_CLKS clocks before a new RAS cycle
  a_r9_pre_len: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE && $past(state_q) != ST_PRE) |=> (state_q == ST_PRE || RP_CLKS < 2));

endmodule

// File: rtl/vmc_strobe_map.sv
module vmc_strobe_map
  import vmc_pkg::*;
(
  input  logic       two_we,
  input  logic       cas_on,
  input  logic       ref_cas,
  input  logic       wr,
  input  logic [1:0] be,
  output logic       stb_a_n,
  output logic       stb_b_n,
  output logic       stb_c_n
);
  localparam int unsigned LANES = 2;

  logic [LANES-1:0] cas_l, we_l;
  logic [1:0]       cas_req, we_req;

  assign cas_req = lane_cas(wr, be);
  assign we_req  = lane_we(wr, be);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cas_l[g] = ref_cas | (cas_on & cas_req[g]);
    assign we_l[g]  = cas_on & we_req[g];
  end

  assign {stb_a_n, stb_b_n, stb_c_n} = pin_fold(two_we, cas_l, we_l);

endmodule

// File: rtl/vmc_dram_ctrl.sv
module vmc_dram_ctrl
  import vmc_pkg::*;
#(
  parameter int unsigned AW         = 10,
  parameter int unsigned DW         = 16,
  parameter int unsigned REF_PERIOD = 256,
  parameter int unsigned RP_CLKS    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_two_we,
  input  logic            cfg_edo,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [2*AW-1:0] req_addr,
  input  logic [1:0]      req_be,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_done,
  output logic [DW-1:0]   rsp_rdata,
  output logic [AW-1:0]   dram_addr,
  output logic            dram_ras_n,
  output logic            dram_stb_a_n,
  output logic            dram_stb_b_n,
  output logic            dram_stb_c_n,
  output logic [DW-1:0]   dram_dq_o,
  output logic            dram_dq_oe,
  input  logic [DW-1:0]   dram_dq_i
);
  logic       ref_pending, ref_taken;
  logic       ras_on, cas_on, ref_cas, wr_q;
  logic [1:0] be_q;
  logic       ev_col_first, ev_ref_ras_first, ev_null, ev_ref_any;

  vmc_refresh_timer #(.PERIOD(REF_PERIOD)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_taken   (ref_taken),
    .ref_pending (ref_pending)
  );

  vmc_sequencer #(.AW(AW), .DW(DW), .RP_CLKS(RP_CLKS)) u_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_edo          (cfg_edo),
    .req_valid        (req_valid),
    .req_write        (req_write),
    .req_addr         (req_addr),
    .req_be           (req_be),
    .req_wdata        (req_wdata),
    .req_ready        (req_ready),
    .rsp_done         (rsp_done),
    .rsp_rdata        (rsp_rdata),
    .ref_pending      (ref_pending),
    .ref_taken        (ref_taken),
    .ras_on           (ras_on),
    .cas_on           (cas_on),
    .ref_cas          (ref_cas),
    .wr_q             (wr_q),
    .be_q             (be_q),
    .mem_addr         (dram_addr),
    .wdata_q          (dram_dq_o),
    .dq_oe            (dram_dq_oe),
    .dq_i             (dram_dq_i),
    .ev_col_first     (ev_col_first),
    .ev_ref_ras_first (ev_ref_ras_first),
    .ev_null          (ev_null),
    .ev_ref_any       (ev_ref_any)
  );

  vmc_strobe_map u_map (
    .two_we  (cfg_two_we),
    .cas_on  (cas_on),
    .ref_cas (ref_cas),
    .wr      (wr_q),
    .be      (be_q),
    .stb_a_n (dram_stb_a_n),
    .stb_b_n (dram_stb_b_n),
    .stb_c_n (dram_stb_c_n)
  );

  assign dram_ras_n = ~ras_on;

  // R9: RAS high for at least two clocks between low periods
  a_r9_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |=> dram_ras_n);

  // R9: column strobe only after RAS has been low a full clock
  a_r9_ras_to_cas: assert property (@(posedge clk) disable iff (!rst_n)
    ev_col_first |-> (!dram_ras_n && $past(!dram_ras_n)));

  // R7: CAS already low in the clock before RAS falls for refresh
  a_r7_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ref_ras_first |-> ($past(dram_ras_n) && $past(!dram_stb_a_n) && !dram_ras_n));

  // R7: no write enable during refresh
  a_r7_we_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ref_any |-> (cfg_two_we ? (dram_stb_b_n && dram_stb_c_n) : dram_stb_c_n));

  // R10: an empty write leaves every strobe quiet
  a_r10_null_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_null |=> (dram_ras_n && dram_stb_a_n && dram_stb_b_n && dram_stb_c_n && rsp_done));

  // R4/R5: CAS width follows the page timing
  a_r5_edo_short_cas: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_col_first && cfg_edo) |=> (dram_stb_a_n && dram_stb_b_n));
  a_r4_normal_long_cas: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_col_first && !cfg_edo) |=> !(dram_stb_a_n && dram_stb_b_n));

  // R1/R2: driving data only while a write holds its column strobe
  a_r2_oe_in_col: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> (!dram_ras_n && !(dram_stb_a_n && dram_stb_b_n)));

endmodule

// File: tb/vmc_dram_ctrl_tb.sv
`timescale 1ns/1ps
module vmc_dram_ctrl_tb;
  import vmc_pkg::*;

  localparam logic [15:0] POISON = 16'hDEAD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_two_we = 1'b0, cfg_edo = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [9:0]  dram_addr;
  logic        dram_ras_n, dram_stb_a_n, dram_stb_b_n, dram_stb_c_n;
  logic [15:0] dram_dq_o;
  logic        dram_dq_oe;
  logic [15:0] dram_dq_i = POISON;

  int unsigned n_vec = 0, n_bad = 0;
  int unsigned cyc = 0, ref_cnt = 0, act_cnt = 0, quiet_viol = 0;

  always #2 clk = ~clk;

  vmc_dram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_two_we(cfg_two_we), .cfg_edo(cfg_edo),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_stb_a_n(dram_stb_a_n),
    .dram_stb_b_n(dram_stb_b_n), .dram_stb_c_n(dram_stb_c_n),
    .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
  );

  // ---------------- bench functions ----------------
  function automatic int unsigned f_idx(input logic [9:0] row, input logic [9:0] col);
    return {26'd0, row[2:0], col[2:0]};
  endfunction
  function automatic logic [15:0] f_init(input int unsigned i);
    return 16'(i * 16'h0101 + 16'h3C5A);
  endfunction
  function automatic logic [15:0] f_merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] be);
    return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
  endfunction
  // expected pins {a,b,c} in the first column clock of an access
  function automatic logic [2:0] f_pins(input logic two_we, input logic wr, input logic [1:0] be);
    if (two_we) return {1'b0, ~(wr & be[0]), ~(wr & be[1])};
    return {~(wr ? be[1] : 1'b1), ~(wr ? be[0] : 1'b1), ~(wr & (|be))};
  endfunction
  function automatic int unsigned f_lat(input logic edo, input logic wr, input logic [1:0] be);
    if (wr && be == 2'b00) return 1;
    if (edo && wr) return 3;
    return 4;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- DRAM pin model ----------------
  logic [15:0] dmem [64];
  logic [15:0] rmem [64];
  logic        op_wr = 1'b0;
  logic [1:0]  op_be = 2'b11;
  logic        p_ras = 1'b0, p_cas = 1'b0, in_ref = 1'b0, seen = 1'b0;
  int unsigned hi_run = 1000;
  logic [9:0]  m_row = '0, m_col = '0;

  always @(negedge clk) begin
    logic ras, cu, cl, wu, wl, cas_any, we_any;
    int unsigned ix;
    if (!rst_n) begin
      p_ras = 1'b0; p_cas = 1'b0; in_ref = 1'b0; seen = 1'b0; hi_run = 1000;
      dram_dq_i = POISON;
    end else begin
      cyc++;
      ras = ~dram_ras_n;
      cu = ~dram_stb_a_n;
      if (cfg_two_we) begin cl = ~dram_stb_a_n; wl = ~dram_stb_b_n; wu = ~dram_stb_c_n; end
      else begin cl = ~dram_stb_b_n; wu = ~dram_stb_c_n; wl = ~dram_stb_c_n; end
      cas_any = cu | cl;
      we_any  = wu | wl;
      if (ras && !p_ras) begin
        check(hi_run >= 2, "R9 precharge clocks", hi_run, 2);
        if (cas_any) begin
          ref_cnt++; in_ref = 1'b1;
          check(p_cas, "R7 CAS before RAS", {31'd0, p_cas}, 1);
        end else begin
          act_cnt++; m_row = dram_addr;
        end
      end
      if (cas_any && (in_ref || !ras))
        check(!we_any, "R7 write enable during refresh", {31'd0, we_any}, 0);
      if (ras && !in_ref && cas_any) begin
        if (!p_cas) begin
          m_col = dram_addr; seen = 1'b1;
          check(p_ras, "R9 RAS-to-CAS", {31'd0, p_ras}, 1);
          check({dram_stb_a_n, dram_stb_b_n, dram_stb_c_n} == f_pins(cfg_two_we, op_wr, op_be),
                cfg_two_we ? "R3 strobe pins" : "R2 strobe pins",
                {29'd0, dram_stb_a_n, dram_stb_b_n, dram_stb_c_n},
                {29'd0, f_pins(cfg_two_we, op_wr, op_be)});
        end
        ix = f_idx(m_row, m_col);
        if (we_any) check(dram_dq_oe, "R2 data drive on write", {31'd0, dram_dq_oe}, 1);
        if (cu && wu) dmem[ix][15:8] = dram_dq_o[15:8];
        if (cl && wl) dmem[ix][7:0]  = dram_dq_o[7:0];
      end
      if (!ras || in_ref) hi_run = ras ? 0 : hi_run + 1;
      else hi_run = 0;
      if (!ras) begin in_ref = 1'b0; seen = 1'b0; end
      if (!dram_ras_n || !dram_stb_a_n || !dram_stb_b_n || !dram_stb_c_n) quiet_viol++;
      ix = f_idx(m_row, m_col);
      if (!cfg_edo) dram_dq_i = (ras && !in_ref && cas_any && !we_any) ? dmem[ix] : POISON;
      else          dram_dq_i = (ras && !in_ref && seen && !cas_any) ? dmem[ix] : POISON;
      p_ras = ras; p_cas = cas_any;
    end
  end

  // ---------------- request driver ----------------
  task automatic do_op(input logic wr, input logic [19:0] addr, input logic [1:0] be,
                       input logic [15:0] wd);
    int unsigned k, guard, ix, q0;
    op_wr = wr; op_be = be;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    check(guard < 100, "R8 request accepted", guard, 0);
    q0 = quiet_viol;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (!rsp_done && k < 40) begin @(negedge clk); k++; end
    check(k == f_lat(cfg_edo, wr, be), "R6 done latency", k, f_lat(cfg_edo, wr, be));
    ix = f_idx(addr[19:10], addr[9:0]);
    if (wr) begin
      rmem[ix] = f_merge(rmem[ix], wd, be);
      if (be == 2'b00) check(quiet_viol == q0, "R10 strobes quiet", quiet_viol - q0, 0);
    end else begin
      check(rsp_rdata == rmem[ix], cfg_edo ? "R5 EDO read data R1" : "R4 normal read data R1",
            {16'd0, rsp_rdata}, {16'd0, rmem[ix]});
    end
    @(negedge clk);
    check(!rsp_done, "R6 done single clock", {31'd0, rsp_done}, 0);
  endtask

  // park a request at the start of a refresh
  task automatic collide(input logic [19:0] addr);
    int unsigned g;
    g = 0;
    while (!(dram_ras_n && !dram_stb_a_n) && g < 400) begin @(negedge clk); g++; end
    check(!req_ready, "R8 ready low during refresh", {31'd0, req_ready}, 0);
    do_op(1'b0, addr, 2'b11, 16'h0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int unsigned r, a0, r0, exp_ref;
    for (int i = 0; i < 64; i++) begin dmem[i] = f_init(i); rmem[i] = f_init(i); end
    r = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    check(dram_ras_n && dram_stb_a_n && dram_stb_b_n && dram_stb_c_n && !dram_dq_oe && !rsp_done,
          "R11 pins in reset", {27'd0, dram_ras_n, dram_stb_a_n, dram_stb_b_n, dram_stb_c_n, dram_dq_oe}, 5'b11110);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && dram_ras_n && !rsp_done, "R11 ready after reset",
          {30'd0, req_ready, rsp_done}, 2);

    for (int m = 0; m < 4; m++) begin
      cfg_two_we = m[1]; cfg_edo = m[0];
      @(negedge clk);
      // directed lane patterns
      do_op(1'b1, 20'h00402, 2'b11, 16'hA1B2);
      do_op(1'b0, 20'h00402, 2'b11, 16'h0);
      do_op(1'b1, 20'h00402, 2'b10, 16'h77CC);
      do_op(1'b0, 20'h00402, 2'b11, 16'h0);
      do_op(1'b1, 20'h00402, 2'b01, 16'h1199);
      do_op(1'b0, 20'h00402, 2'b11, 16'h0);
      // row/column swap sensitivity
      do_op(1'b1, 20'h00C01, 2'b11, 16'h5151);
      do_op(1'b0, 20'h00403, 2'b11, 16'h0);
      do_op(1'b0, 20'h00C01, 2'b11, 16'h0);
      // address extremes
      do_op(1'b1, 20'hFFFFF, 2'b11, 16'hFACE);
      do_op(1'b0, 20'hFFFFF, 2'b11, 16'h0);
      do_op(1'b1, 20'h00000, 2'b11, 16'h0F0F);
      do_op(1'b0, 20'h00000, 2'b11, 16'h0);
      // empty write (R10) then read back unchanged
      a0 = act_cnt;
      do_op(1'b1, 20'h00402, 2'b00, 16'hFFFF);
      check(act_cnt == a0, "R10 no RAS cycle", act_cnt - a0, 0);
      do_op(1'b0, 20'h00402, 2'b11, 16'h0);
      // refresh collision (R8)
      collide(20'h00C01);
      collide(20'hFFFFF);
      // random traffic
      for (int k = 0; k < 70; k++) begin
        r = $urandom;
        do_op(r[0], {r[31:22], r[17:8]}, r[3:2], r[31:16] ^ r[15:0]);
      end
    end

    // refresh rate (R7)
    r0 = ref_cnt;
    exp_ref = cyc / 256;
    check((r0 + 1 >= exp_ref) && (r0 <= exp_ref + 1), "R7 refresh count", r0, exp_ref);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule